// File: doc/BRIEF.md
# Phase-correct PWM timer

This block is an 8-bit timer that produces a centre-aligned PWM waveform. The counter climbs from zero to its top value (255) and then falls back to zero. It compares the count against a compare value on both slopes, so every high pulse sits symmetrically around the bottom of the count. The count advances only on a synchronous enable pulse, produced by a built-in prescaler from the system clock. A full up-and-down cycle takes 510 enable pulses, so the output frequency is the clock frequency divided by 510 times the prescale factor.

Software-side logic writes a new compare value through a one-cycle write strobe. The value is held in a shadow register and adopted only when the count turns at the top, so one period never mixes two duty cycles. An invert select complements the output level. Two single-cycle flags report the arrival at bottom and each compare match. The two extreme compare values give a constant level. At the top turning point the output is forced to the up-slope match level. This keeps the waveform symmetric when the compare value drops away from the top value, or when a newly adopted value lies below the current count.

Top module: `pwm_phase_timer`

## Requirements
- R1: After reset the count starts at 0 and rises by one per enable pulse to 255, then falls by one per pulse back to 0, repeating. One period is 510 enable pulses.
- R2: `presc_sel` picks the enable rate: 1 gives a pulse every clock, 2 every 8 clocks, 3 every 64, 4 every 256 and 5 every 1024. The values 0, 6 and 7 stop the count, and the flags and output then stay still.
- R3: With `invert` low and a compare value c, the output goes low when the rising count reaches c and goes high when the falling count reaches c. The output is therefore high for 2·c enable pulses of each 510.
- R4: With `invert` low, a compare value of 0 holds the output low for the whole period and a value of 255 holds it high for the whole period.
- R5: With `invert` high, every output level, including both extremes, is the complement of the level given for `invert` low. The invert select acts on the output immediately.
- R6: A value written with `cmp_wr` is adopted only on the enable pulse that brings the count to 255. Until then the old value governs all matches.
- R7: On the pulse that brings the count to 255, the output takes the up-slope match level of the newly adopted value: low, unless that value is 255. This holds even when no match occurs, for example when the value drops from 255.
- R8: `ovf_flag` is high for exactly one clock, in the cycle after the enable pulse that brings the falling count to 0.
- R9: `cmp_flag` is high for exactly one clock after each enable pulse on which the new count equals the compare value in force, on either slope. This gives two pulses per period for values 1 to 254.
- R10: A synchronous reset clears the count, the prescaler, the shadow and active compare values, both flags and the output level, and sets the direction to rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| presc_sel | input | 3 | Enable-rate select (see R2) |
| cmp_wr | input | 1 | Write strobe for the shadow compare value |
| cmp_wdata | input | 8 | Compare value to write |
| invert | input | 1 | Complement the output level when high |
| pwm_out | output | 1 | PWM waveform |
| ovf_flag | output | 1 | One-clock pulse when the count reaches bottom |
| cmp_flag | output | 1 | One-clock pulse on each compare match |

## Verification
The hardest situation to reach from the ports is the top turning point in the cycle where a new compare value is adopted. The forced level there differs from ordinary match behaviour only when the old value was 255, or when the write lands partway through a rising slope. The count is not visible at the ports. The stimulus therefore runs at divide-by-one, aligns to the bottom pulse, and then counts clocks so that it knows the count at every edge. It places compare writes at chosen points of the rising slope and checks the output and both flags on every cycle of each period against levels worked out from the count.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  localparam int PRE_W = 10;

  typedef enum logic [2:0] {
    PS_STOP    = 3'd0,
    PS_DIV1    = 3'd1,
    PS_DIV8    = 3'd2,
    PS_DIV64   = 3'd3,
    PS_DIV256  = 3'd4,
    PS_DIV1024 = 3'd5
  } presc_e;

  typedef struct packed {
    logic             run;
    logic [PRE_W-1:0] mask;
  } presc_tap_t;

  // Log2 of the division ratio for each select code.
  function automatic int presc_shift(input logic [2:0] sel);
    case (sel)
      PS_DIV1:    return 0;
      PS_DIV8:    return 3;
      PS_DIV64:   return 6;
      PS_DIV256:  return 8;
      PS_DIV1024: return 10;
      default:    return -1;
    endcase
  endfunction

  function automatic presc_tap_t presc_decode(input logic [2:0] sel);
    presc_tap_t t;
    int sh;
    sh = presc_shift(sel);
    t.run  = (sh >= 0);
    t.mask = (sh > 0) ? PRE_W'((1 << sh) - 1) : '0;
    return t;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);

  presc_tap_t       tap;
  logic [PRE_W-1:0] div_q;

  always_comb tap = presc_decode(sel);

  // Enable pulse once every 2^shift clocks while running.
  assign tick = tap.run && ((div_q & tap.mask) == tap.mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
    end else if (tap.run) begin
      div_q <= div_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/pwm_updown_counter.sv
module pwm_updown_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] nxt_cnt,
  output logic         up_q,
  output logic         top_evt,
  output logic         bot_evt,
  output logic         ovf_flag
);

  localparam logic [W-1:0] TOP_V = '1;

  always_comb begin
    nxt_cnt = up_q ? cnt_q + W'(1) : cnt_q - W'(1);
    top_evt = tick && up_q && (nxt_cnt == TOP_V);
    bot_evt = tick && !up_q && (nxt_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      up_q     <= 1'b1;
      ovf_flag <= 1'b0;
    end else begin
      ovf_flag <= bot_evt;
      if (tick) begin
        cnt_q <= nxt_cnt;
        if (top_evt) begin
          up_q <= 1'b0;
        end else if (bot_evt) begin
          up_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pwm_compare_unit.sv
module pwm_compare_unit #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] nxt_cnt,
  input  logic         up_q,
  input  logic         top_evt,
  output logic [W-1:0] cmp_act,
  output logic         lvl_q,
  output logic         cmp_hit,
  output logic         cmp_flag
);

  localparam logic [W-1:0] TOP_V = '1;

  logic [W-1:0] cmp_buf;

  // Level forced when the count turns at the top: the up-slope match
  // result of the value being adopted (high only for the full-scale value).
  function automatic logic turn_level(input logic [W-1:0] v);
    return (v == TOP_V);
  endfunction

  // Level after a match: rising clears, falling sets unless value is zero.
  function automatic logic match_level(input logic rising, input logic [W-1:0] v);
    return rising ? 1'b0 : (v != '0);
  endfunction

  assign cmp_hit = tick && (nxt_cnt == cmp_act);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_buf  <= '0;
      cmp_act  <= '0;
      lvl_q    <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      cmp_flag <= cmp_hit;
      if (wr_en) begin
        cmp_buf <= wr_data;
      end
      if (top_evt) begin
        cmp_act <= cmp_buf;
        lvl_q   <= turn_level(cmp_buf);
      end else if (cmp_hit) begin
        lvl_q   <= match_level(up_q, cmp_act);
      end
    end
  end

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       presc_sel,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             invert,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             cmp_flag
);

  logic             tick;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt_cnt;
  logic             up_q;
  logic             top_evt;
  logic             bot_evt;
  logic [CNT_W-1:0] cmp_act;
  logic             lvl_q;
  logic             cmp_hit;

  pwm_prescaler u_presc (
    .clk  (clk),
    .rst  (rst),
    .sel  (presc_sel),
    .tick (tick)
  );

  pwm_updown_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt_q    (cnt_q),
    .nxt_cnt  (nxt_cnt),
    .up_q     (up_q),
    .top_evt  (top_evt),
    .bot_evt  (bot_evt),
    .ovf_flag (ovf_flag)
  );

  pwm_compare_unit #(.W(CNT_W)) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .wr_en    (cmp_wr),
    .wr_data  (cmp_wdata),
    .nxt_cnt  (nxt_cnt),
    .up_q     (up_q),
    .top_evt  (top_evt),
    .cmp_act  (cmp_act),
    .lvl_q    (lvl_q),
    .cmp_hit  (cmp_hit),
    .cmp_flag (cmp_flag)
  );

  assign pwm_out = lvl_q ^ invert;

endmodule

// File: rtl/pwm_phase_timer_chk.sv
module pwm_phase_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         top_evt,
  input logic         bot_evt,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cmp_act,
  input logic         lvl_q,
  input logic         cmp_hit,
  input logic         invert,
  input logic         pwm_out,
  input logic         ovf_flag,
  input logic         cmp_flag
);

  localparam logic [W-1:0] ONE_V = 1;
  localparam logic [W-1:0] TOP_V = '1;

  a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((cnt_q == $past(cnt_q) + ONE_V) || (cnt_q == $past(cnt_q) - ONE_V)));

  a_r2_hold_count: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  a_r4_zero_low: assert property (@(posedge clk) disable iff (rst)
    (cmp_act == '0) |-> (pwm_out == invert));

  a_r4_full_high: assert property (@(posedge clk) disable iff (rst)
    (cmp_act == TOP_V) |-> (pwm_out == !invert));

  a_r6_active_stable: assert property (@(posedge clk) disable iff (rst)
    !top_evt |=> $stable(cmp_act));

  a_r7_turn_level: assert property (@(posedge clk) disable iff (rst)
    top_evt |=> (lvl_q == (cmp_act == TOP_V)));

  a_r8_ovf_follows: assert property (@(posedge clk) disable iff (rst)
    bot_evt |=> ovf_flag);

  a_r8_ovf_single: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> !ovf_flag);

  a_r9_flag_follows: assert property (@(posedge clk) disable iff (rst)
    cmp_hit |=> cmp_flag);

  a_r9_flag_qualified: assert property (@(posedge clk) disable iff (rst)
    cmp_flag |-> $past(tick));

endmodule

bind pwm_phase_timer pwm_phase_timer_chk #(.W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .top_evt  (top_evt),
  .bot_evt  (bot_evt),
  .cnt_q    (cnt_q),
  .cmp_act  (cmp_act),
  .lvl_q    (lvl_q),
  .cmp_hit  (cmp_hit),
  .invert   (invert),
  .pwm_out  (pwm_out),
  .ovf_flag (ovf_flag),
  .cmp_flag (cmp_flag)
);

// File: tb/pwm_phase_timer_test.sv
module pwm_phase_timer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] presc_sel = 3'd1;
  logic       cmp_wr = 1'b0;
  logic [7:0] cmp_wdata = '0;
  logic       invert = 1'b0;
  logic       pwm_out;
  logic       ovf_flag;
  logic       cmp_flag;

  int n_checks = 0;
  int n_errs   = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_phase_timer uut (
    .clk       (clk),
    .rst       (rst),
    .presc_sel (presc_sel),
    .cmp_wr    (cmp_wr),
    .cmp_wdata (cmp_wdata),
    .invert    (invert),
    .pwm_out   (pwm_out),
    .ovf_flag  (ovf_flag),
    .cmp_flag  (cmp_flag)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One period at divide-by-one, starting at the negedge where count = 0.
  // cu: compare value in force on the rising slope, cd: value adopted at top.
  // A write of wv is issued after sampling at position wk (-1: none).
  task automatic run_period(input int cu, input int cd, input int wk,
                            input int wv, input string tag);
    int pm = 0, fm = 0, fpm = -1, fpa = 0, fpe = 0;
    for (int k = 1; k <= 510; k++) begin
      int  cnt;
      bit  el, ef, eo;
      @(negedge clk);
      if (k < 255) begin
        cnt = k;      el = (cnt < cu);              ef = (cnt == cu);
      end else if (k == 255) begin
        cnt = 255;    el = (cd == 255);             ef = (cu == 255);
      end else begin
        cnt = 510 - k; el = (cd != 0) && (cnt <= cd); ef = (cnt == cd);
      end
      eo = (k == 510);
      if (pwm_out !== (el ^ invert)) begin
        pm++;
        if (fpm < 0) begin fpm = k; fpa = pwm_out; fpe = el ^ invert; end
      end
      if (cmp_flag !== ef || ovf_flag !== eo) fm++;
      cmp_wr    = (k == wk);
      cmp_wdata = 8'(wv);
    end
    check(pm == 0, tag, $sformatf("pwm level mismatches cu=%0d cd=%0d inv=%0d first at %0d (pwm %0d vs %0d)",
          cu, cd, invert, fpm, fpa, fpe), pm, 0);
    check(fm == 0, "R1 R8 R9", $sformatf("flag mismatches cu=%0d cd=%0d", cu, cd), fm, 0);
  endtask

  task automatic wait_ovf();
    do @(negedge clk); while (!ovf_flag);
  endtask

  initial begin
    repeat (20000 * 10 - 5000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    int prev, c, gap, pulses;
    bit p0, moved;

    // R10: reset state
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R10", "pwm after reset", pwm_out, 0);
    check(ovf_flag == 1'b0 && cmp_flag == 1'b0, "R10", "flags after reset",
          ovf_flag + cmp_flag, 0);
    rst = 1'b0;  // this negedge is count position 0

    // R1 R6: first period from reset, new value written mid-rise
    run_period(0, 100, 10, 100, "R1 R6");
    run_period(100, 100, -1, 0, "R3");
    // R6: write 50 while rising; 100 must still govern the rising slope
    run_period(100, 50, 20, 50, "R6");
    run_period(50, 255, 30, 255, "R4");
    run_period(255, 255, -1, 0, "R4");
    // R7: leaving full scale forces the output low at the top without a match
    run_period(255, 100, 40, 100, "R7");
    invert = 1'b1;
    run_period(100, 100, -1, 0, "R5");
    invert = 1'b0;
    run_period(100, 0, 5, 0, "R4");
    run_period(0, 0, -1, 0, "R4");
    invert = 1'b1;
    run_period(0, 0, -1, 0, "R5");
    invert = 1'b0;

    // R3 R5: sweep of compare values, alternate inverted periods
    prev = 0;
    for (int v = 0; v < 46; v++) begin
      c = (v < 43) ? 1 + 6 * v : ((v == 43) ? 254 : 255);
      run_period(prev, c, 5, c, "R3");
      invert = v[0];
      run_period(c, c, -1, 0, v[0] ? "R5" : "R3");
      invert = 1'b0;
      prev = c;
    end

    // R2: divide by 8 and by 64, measured between bottom pulses
    presc_sel = 3'd2;
    wait_ovf();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!ovf_flag);
    check(gap == 4080, "R2", "period clocks at select 2", gap, 4080);
    presc_sel = 3'd3;
    wait_ovf();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!ovf_flag);
    check(gap == 32640, "R2", "period clocks at select 3", gap, 32640);

    // R2: select 0 and 7 stop everything
    for (int s = 0; s < 2; s++) begin
      presc_sel = (s == 0) ? 3'd0 : 3'd7;
      @(negedge clk);
      p0 = pwm_out; pulses = 0; moved = 1'b0;
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        pulses += ovf_flag + cmp_flag;
        if (pwm_out != p0) moved = 1'b1;
      end
      check(pulses == 0 && !moved, "R2", "activity while stopped", pulses + moved, 0);
    end

    // R10: mid-run reset, then a clean period from zero
    presc_sel = 3'd1;
    cmp_wr = 1'b1; cmp_wdata = 8'd77;
    repeat (700) @(negedge clk);
    cmp_wr = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(pwm_out == 1'b0 && ovf_flag == 1'b0 && cmp_flag == 1'b0, "R10",
          "outputs during mid-run reset", pwm_out + ovf_flag + cmp_flag, 0);
    rst = 1'b0;
    // shadow value must have been cleared: 0 stays in force through the top
    run_period(0, 0, -1, 0, "R10");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule